// File: doc/BRIEF.md
# Set/Clear Interrupt Enable Register Bank

This block holds a small bank of interrupt enable registers behind a simple memory-mapped bus. Each register occupies two word addresses: an even "set" address and an odd "clear" address. A register configured as dual-address turns a write to its set address into a bitwise OR with the stored value. A write to its clear address removes the written ones. A set-only register is overwritten by a write to its set address. A clear-only register can only lose bits, through its clear address.

Every register is divided into equal fields of a configured width. A width of one gives one enable bit per source. A wider width gives priority-style fields, where any nonzero value means the source is enabled. Each field is tied to a configured source identifier, and identifier zero marks a field as unused.

When a write changes one or more fields, the block issues one change event per clock for each affected source. An event reports the source identifier and whether the source is now enabled. The bus is stalled until the last event of a write has been issued. Downstream logic counts these events per source and aggregates them into a pending interrupt.

Top module: `intcMaskBank`

## Requirements
- R1: After reset, every register holds its configured reset value (defaults: registers 0 to 2 are 0x00 and register 3 is 0xFF), busReady is 1 and evtValid is 0.
- R2: A write to the set address (2*r) of a dual-address register r stores the old value OR the write data.
- R3: A write to the clear address (2*r+1) of a dual-address or clear-only register stores the old value AND NOT the write data.
- R4: A write to the set address of a set-only register replaces its contents with the write data.
- R5: A read returns the stored register from either of its mapped addresses, and returns 0 from an unmapped address. The unmapped addresses are the clear address of a set-only register, the set address of a clear-only register, and any index at or beyond the register count.
- R6: A write to an unmapped address changes no register and produces no event.
- R7: An event is issued only for a field whose contents changed. Field k of a register with F fields of width W occupies bits starting at (F-1-k)*W. evtEnable is 1 when the new field value is nonzero and 0 otherwise, and evtSrc carries the identifier of that field.
- R8: Events of one write start in the cycle after the write is accepted. They appear one per cycle on consecutive cycles, from field 0 (most significant) upward.
- R9: busReady is 0 in every cycle in which an event is still being issued, and a request waiting in that time is accepted only after the last event. A write that changes no used field keeps busReady at 1.
- R10: A field whose identifier is 0 never produces an event, even when its bits change.
- R11: A multi-bit field that changes from one nonzero value to another nonzero value produces an enable event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busValid | input | 1 | Bus request present |
| busWrite | input | 1 | 1 for write, 0 for read |
| busAddr | input | ADDR_W | Word address; bits above bit 0 give the register, bit 0 selects the clear address |
| busWdata | input | REG_W | Write data |
| busReady | output | 1 | Request accepted in this cycle; 0 while events are outstanding |
| busRdata | output | REG_W | Read data for the addressed register, 0 when unmapped |
| evtValid | output | 1 | A change event is present |
| evtEnable | output | 1 | 1 for an enable event, 0 for a disable event |
| evtSrc | output | ID_W | Source identifier of the event |

## Verification
Issuing events and accepting a new bus request are the two functions that compete for the same cycles. The bench provokes the overlap by raising a second write right after the first one is accepted and holding it while the first write's events are still being issued. In each of those cycles it checks that busReady is 0 and that the events arrive in field order. It then checks that the second write is taken only after the first write's last event, that its events follow as a separate group, and that the register read back afterwards reflects both writes in order.

// File: rtl/intcMaskPkg.sv
package intcMaskPkg;

  typedef enum logic [1:0] {
    KIND_DUAL     = 2'd0,
    KIND_SET_ONLY = 2'd1,
    KIND_CLR_ONLY = 2'd2
  } regKind_e;

  // strobes from the control unit to the datapath
  typedef struct packed {
    logic commitWrite;
  } ctrlStrobe_t;

  localparam int DEF_NUM_REGS = 4;
  localparam int DEF_REG_W    = 8;
  localparam int DEF_ID_W     = 6;
  localparam int DEF_FW_BITS  = 4;
  localparam int DEF_ADDR_W   = 4;

  // register 3 .. register 0
  localparam logic [DEF_NUM_REGS*2-1:0] DEF_KIND =
    {KIND_CLR_ONLY, KIND_SET_ONLY, KIND_DUAL, KIND_DUAL};
  localparam logic [DEF_NUM_REGS*DEF_FW_BITS-1:0] DEF_FIELD_W =
    {4'd1, 4'd2, 4'd4, 4'd1};
  localparam logic [DEF_NUM_REGS*DEF_REG_W-1:0] DEF_RESET =
    {8'hFF, 8'h00, 8'h00, 8'h00};

  // identifier of field k of register r is r*REG_W+k+1; one field left unused
  function automatic logic [DEF_NUM_REGS*DEF_REG_W*DEF_ID_W-1:0] defaultSrcIds();
    logic [DEF_NUM_REGS*DEF_REG_W*DEF_ID_W-1:0] tbl;
    int id;
    tbl = '0;
    for (int r = 0; r < DEF_NUM_REGS; r++) begin
      for (int k = 0; k < DEF_REG_W; k++) begin
        id = (r == 0 && k == 3) ? 0 : r * DEF_REG_W + k + 1;
        tbl[(r*DEF_REG_W+k)*DEF_ID_W +: DEF_ID_W] = DEF_ID_W'(id);
      end
    end
    return tbl;
  endfunction

endpackage

// File: rtl/intcMaskDatapath.sv
module intcMaskDatapath
  import intcMaskPkg::*;
#(
  parameter int NUM_REGS = DEF_NUM_REGS,
  parameter int REG_W    = DEF_REG_W,
  parameter int ID_W     = DEF_ID_W,
  parameter int FW_BITS  = DEF_FW_BITS,
  parameter int ADDR_W   = DEF_ADDR_W,
  parameter logic [NUM_REGS*2-1:0]          KIND_CFG    = DEF_KIND,
  parameter logic [NUM_REGS*FW_BITS-1:0]    FIELD_W_CFG = DEF_FIELD_W,
  parameter logic [NUM_REGS*REG_W-1:0]      RESET_CFG   = DEF_RESET,
  parameter logic [NUM_REGS*REG_W*ID_W-1:0] SRC_ID_CFG  = defaultSrcIds()
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  ctrlStrobe_t                   strobe,
  input  logic [ADDR_W-1:0]             busAddr,
  input  logic [REG_W-1:0]              busWdata,
  output logic [REG_W-1:0]              busRdata,
  output logic                          addrHit,
  output logic [REG_W-1:0]              fieldChanged,
  output logic [REG_W-1:0]              fieldEnable,
  output logic [REG_W-1:0][ID_W-1:0]    fieldSrc
);

  localparam int IDX_W = ADDR_W - 1;
  localparam int SEL_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

  logic [NUM_REGS-1:0][REG_W-1:0] regs;
  logic [IDX_W-1:0]   regIdx;
  logic               isClr;
  logic [SEL_W-1:0]   selR;
  logic [FW_BITS-1:0] selFw;
  regKind_e           selKind;
  regKind_e           rKind;
  logic [REG_W-1:0]   curVal;
  logic [REG_W-1:0]   newVal;
  logic [REG_W-1:0]   fieldMask;
  int                 numFields;
  int                 shiftAmt;

  assign regIdx = busAddr[ADDR_W-1:1];
  assign isClr  = busAddr[0];

  // address decode: which register, and is this alias mapped for its kind
  always_comb begin
    addrHit = 1'b0;
    curVal  = '0;
    selR    = '0;
    selFw   = FW_BITS'(1);
    selKind = KIND_DUAL;
    rKind   = KIND_DUAL;
    for (int r = 0; r < NUM_REGS; r++) begin
      if (regIdx == IDX_W'(r)) begin
        rKind = regKind_e'(KIND_CFG[2*r +: 2]);
        if ((rKind == KIND_DUAL) ||
            (rKind == KIND_SET_ONLY && !isClr) ||
            (rKind == KIND_CLR_ONLY && isClr)) begin
          addrHit = 1'b1;
          curVal  = regs[r];
          selR    = SEL_W'(r);
          selFw   = FIELD_W_CFG[r*FW_BITS +: FW_BITS];
          selKind = rKind;
        end
      end
    end
  end

  // write-to-modify rule
  always_comb begin
    if (isClr) begin
      newVal = curVal & ~busWdata;
    end else if (selKind == KIND_SET_ONLY) begin
      newVal = busWdata;
    end else begin
      newVal = curVal | busWdata;
    end
  end

  // per-field comparison of old and new contents, field 0 most significant
  always_comb begin
    numFields    = REG_W / ((selFw == '0) ? 1 : int'(selFw));
    fieldChanged = '0;
    fieldEnable  = '0;
    fieldSrc     = '0;
    fieldMask    = '0;
    shiftAmt     = 0;
    for (int k = 0; k < REG_W; k++) begin
      if (k < numFields) begin
        shiftAmt        = (numFields - 1 - k) * int'(selFw);
        fieldMask       = REG_W'((1 << selFw) - 1) << shiftAmt;
        fieldSrc[k]     = SRC_ID_CFG[(int'(selR)*REG_W + k)*ID_W +: ID_W];
        fieldEnable[k]  = |(newVal & fieldMask);
        fieldChanged[k] = addrHit && (fieldSrc[k] != '0) &&
                          (|((curVal ^ newVal) & fieldMask));
      end
    end
  end

  // register storage
  for (genvar g = 0; g < NUM_REGS; g++) begin : gReg
    always_ff @(posedge clk) begin
      if (!rstN) begin
        regs[g] <= RESET_CFG[g*REG_W +: REG_W];
      end else if (strobe.commitWrite && addrHit && (selR == SEL_W'(g))) begin
        regs[g] <= newVal;
      end
    end
  end

  assign busRdata = addrHit ? curVal : '0;

endmodule

// File: rtl/intcMaskControl.sv
module intcMaskControl
  import intcMaskPkg::*;
#(
  parameter int REG_W = DEF_REG_W,
  parameter int ID_W  = DEF_ID_W
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       busValid,
  input  logic                       busWrite,
  input  logic                       addrHit,
  input  logic [REG_W-1:0]           fieldChanged,
  input  logic [REG_W-1:0]           fieldEnable,
  input  logic [REG_W-1:0][ID_W-1:0] fieldSrc,
  output ctrlStrobe_t                strobe,
  output logic                       busReady,
  output logic                       evtValid,
  output logic                       evtEnable,
  output logic [ID_W-1:0]            evtSrc
);

  logic [REG_W-1:0]           pendMask;
  logic [REG_W-1:0]           enLatch;
  logic [REG_W-1:0][ID_W-1:0] srcLatch;
  logic [REG_W-1:0]           pickOh;
  logic [REG_W-1:0][ID_W-1:0] srcMasked;
  logic                       busy;

  assign busy     = |pendMask;
  assign busReady = !busy;
  assign strobe.commitWrite = busValid && busWrite && !busy;

  // lowest pending index is the most significant field still owed
  assign pickOh = pendMask & (~pendMask + 1'b1);

  for (genvar g = 0; g < REG_W; g++) begin : gSel
    assign srcMasked[g] = pickOh[g] ? srcLatch[g] : '0;
  end

  always_comb begin
    evtSrc = '0;
    for (int k = 0; k < REG_W; k++) begin
      evtSrc = evtSrc | srcMasked[k];
    end
  end

  assign evtValid  = busy;
  assign evtEnable = |(pickOh & enLatch);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendMask <= '0;
      enLatch  <= '0;
      srcLatch <= '0;
    end else if (strobe.commitWrite) begin
      pendMask <= addrHit ? fieldChanged : '0;
      enLatch  <= fieldEnable;
      srcLatch <= fieldSrc;
    end else begin
      pendMask <= pendMask & ~pickOh;
    end
  end

endmodule

// File: rtl/intcMaskBank.sv
module intcMaskBank
  import intcMaskPkg::*;
#(
  parameter int NUM_REGS = DEF_NUM_REGS,
  parameter int REG_W    = DEF_REG_W,
  parameter int ID_W     = DEF_ID_W,
  parameter int FW_BITS  = DEF_FW_BITS,
  parameter int ADDR_W   = DEF_ADDR_W,
  parameter logic [NUM_REGS*2-1:0]          KIND_CFG    = DEF_KIND,
  parameter logic [NUM_REGS*FW_BITS-1:0]    FIELD_W_CFG = DEF_FIELD_W,
  parameter logic [NUM_REGS*REG_W-1:0]      RESET_CFG   = DEF_RESET,
  parameter logic [NUM_REGS*REG_W*ID_W-1:0] SRC_ID_CFG  = defaultSrcIds()
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [REG_W-1:0]  busWdata,
  output logic              busReady,
  output logic [REG_W-1:0]  busRdata,
  output logic              evtValid,
  output logic              evtEnable,
  output logic [ID_W-1:0]   evtSrc
);

  ctrlStrobe_t                strobe;
  logic                       addrHit;
  logic [REG_W-1:0]           fieldChanged;
  logic [REG_W-1:0]           fieldEnable;
  logic [REG_W-1:0][ID_W-1:0] fieldSrc;

  intcMaskDatapath #(
    .NUM_REGS(NUM_REGS), .REG_W(REG_W), .ID_W(ID_W), .FW_BITS(FW_BITS),
    .ADDR_W(ADDR_W), .KIND_CFG(KIND_CFG), .FIELD_W_CFG(FIELD_W_CFG),
    .RESET_CFG(RESET_CFG), .SRC_ID_CFG(SRC_ID_CFG)
  ) uDatapath (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .addrHit(addrHit), .fieldChanged(fieldChanged),
    .fieldEnable(fieldEnable), .fieldSrc(fieldSrc)
  );

  intcMaskControl #(.REG_W(REG_W), .ID_W(ID_W)) uControl (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .addrHit(addrHit), .fieldChanged(fieldChanged),
    .fieldEnable(fieldEnable), .fieldSrc(fieldSrc),
    .strobe(strobe), .busReady(busReady),
    .evtValid(evtValid), .evtEnable(evtEnable), .evtSrc(evtSrc)
  );

endmodule

// File: rtl/intcMaskChecker.sv
module intcMaskChecker #(
  parameter int NUM_REGS = 4,
  parameter int REG_W    = 8,
  parameter int ID_W     = 6,
  parameter int ADDR_W   = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              busValid,
  input logic              busWrite,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busReady,
  input logic [REG_W-1:0]  busRdata,
  input logic              evtValid,
  input logic [ID_W-1:0]   evtSrc
);

  logic unmapped;
  assign unmapped = int'(busAddr) >= 2 * NUM_REGS;

  p_busy_blocks_r9: assert property (@(posedge clk) disable iff (!rstN)
    evtValid |-> !busReady);

  p_src_used_r10: assert property (@(posedge clk) disable iff (!rstN)
    evtValid |-> (evtSrc != '0));

  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    (busReady && !(busValid && busWrite)) |=> !evtValid);

  p_unmapped_read_r5: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && !busWrite && unmapped) |-> (busRdata == '0));

  p_unmapped_write_r6: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && busWrite && busReady && unmapped) |=> !evtValid);

endmodule

bind intcMaskBank intcMaskChecker #(
  .NUM_REGS(NUM_REGS), .REG_W(REG_W), .ID_W(ID_W), .ADDR_W(ADDR_W)
) uChk (
  .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
  .busAddr(busAddr), .busReady(busReady), .busRdata(busRdata),
  .evtValid(evtValid), .evtSrc(evtSrc)
);

// File: tb/sim_intcMaskBank.sv
module sim_intcMaskBank;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       busValid = 1'b0;
  logic       busWrite = 1'b0;
  logic [3:0] busAddr = '0;
  logic [7:0] busWdata = '0;
  logic       busReady;
  logic [7:0] busRdata;
  logic       evtValid;
  logic       evtEnable;
  logic [5:0] evtSrc;

  int tests = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 1'b0;

  logic [6:0] got [16];
  int         gotN;

  intcMaskBank u0 (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busReady(busReady),
    .busRdata(busRdata), .evtValid(evtValid), .evtEnable(evtEnable),
    .evtSrc(evtSrc)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct packed {
    logic [3:0]  addr;
    logic [7:0]  wdata;
    logic [3:0]  raddr;
    logic [7:0]  rexp;
    logic [1:0]  nev;
    logic [20:0] evs;   // first event in the low 7 bits, each {enable, id}
  } vec_t;

  localparam vec_t TBL [13] = '{
    '{4'd0, 8'h81, 4'd1, 8'h81, 2'd2, {7'd0, 1'b1, 6'd8, 1'b1, 6'd1}},  // R2 R7
    '{4'd0, 8'h11, 4'd0, 8'h91, 2'd0, 21'd0},                           // R10 R9
    '{4'd1, 8'h80, 4'd0, 8'h11, 2'd1, {14'd0, 1'b0, 6'd1}},             // R3
    '{4'd2, 8'h30, 4'd3, 8'h30, 2'd1, {14'd0, 1'b1, 6'd9}},             // R7 R5
    '{4'd2, 8'h05, 4'd3, 8'h35, 2'd1, {14'd0, 1'b1, 6'd10}},            // R7
    '{4'd3, 8'h10, 4'd2, 8'h25, 2'd1, {14'd0, 1'b1, 6'd9}},             // R11
    '{4'd3, 8'h25, 4'd2, 8'h00, 2'd2, {7'd0, 1'b0, 6'd10, 1'b0, 6'd9}}, // R8
    '{4'd4, 8'hC6, 4'd4, 8'hC6, 2'd3, {1'b1, 6'd20, 1'b1, 6'd19, 1'b1, 6'd17}}, // R4
    '{4'd4, 8'h06, 4'd4, 8'h06, 2'd1, {14'd0, 1'b0, 6'd17}},            // R4
    '{4'd7, 8'h41, 4'd7, 8'hBE, 2'd2, {7'd0, 1'b0, 6'd32, 1'b0, 6'd26}},// R3 clear-only
    '{4'd5, 8'hFF, 4'd5, 8'h00, 2'd0, 21'd0},                           // R6 R5
    '{4'd6, 8'hFF, 4'd6, 8'h00, 2'd0, 21'd0},                           // R6 R5
    '{4'd9, 8'hFF, 4'd9, 8'h00, 2'd0, 21'd0}                            // R6 R5
  };

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  // collect events on consecutive cycles, starting at the negedge after acceptance
  task automatic collect(input string req);
    gotN = 0;
    while (evtValid) begin
      check(req, "busReady while events owed", {31'd0, busReady}, 32'd0);
      if (gotN < 16) got[gotN] = {evtEnable, evtSrc};
      gotN++;
      @(negedge clk);
    end
  endtask

  task automatic doWrite(input logic [3:0] a, input logic [7:0] d, input string req);
    @(negedge clk);
    busValid = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = d;
    while (!busReady) @(negedge clk);
    @(negedge clk);
    busValid = 1'b0; busWrite = 1'b0;
    collect(req);
  endtask

  task automatic doRead(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    busValid = 1'b1; busWrite = 1'b0; busAddr = a;
    #1;
    d = busRdata;
    @(negedge clk);
    busValid = 1'b0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !done) begin
      done = 1'b1;
      tests++; fails++;
      $display("FAIL R8 watchdog: actual %0d cycles expected < %0d", cycles, WATCHDOG);
      finishRun();
    end
  end

  initial begin
    logic [7:0] rd;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    check("R1", "busReady", {31'd0, busReady}, 32'd1);
    check("R1", "evtValid", {31'd0, evtValid}, 32'd0);
    doRead(4'd0, rd); check("R1", "reg0", {24'd0, rd}, 32'h00);
    doRead(4'd2, rd); check("R1", "reg1", {24'd0, rd}, 32'h00);
    doRead(4'd4, rd); check("R1", "reg2", {24'd0, rd}, 32'h00);
    doRead(4'd7, rd); check("R1", "reg3", {24'd0, rd}, 32'hFF);

    // table walk: R2 R3 R4 R5 R6 R7 R8 R10 R11
    for (int i = 0; i < 13; i++) begin
      doWrite(TBL[i].addr, TBL[i].wdata, "R7");
      check("R7", $sformatf("vec %0d event count", i), gotN, {30'd0, TBL[i].nev});
      for (int e = 0; e < int'(TBL[i].nev); e++) begin
        if (e < gotN)
          check("R8", $sformatf("vec %0d event %0d", i, e),
                {25'd0, got[e]}, {25'd0, TBL[i].evs[e*7 +: 7]});
      end
      check("R9", $sformatf("vec %0d ready after drain", i), {31'd0, busReady}, 32'd1);
      doRead(TBL[i].raddr, rd);
      check("R5", $sformatf("vec %0d readback", i), {24'd0, rd}, {24'd0, TBL[i].rexp});
    end

    // R6: unmapped writes left neighbours untouched
    doRead(4'd4, rd); check("R6", "reg2 after unmapped write", {24'd0, rd}, 32'h06);
    doRead(4'd7, rd); check("R6", "reg3 after unmapped write", {24'd0, rd}, 32'hBE);

    // R9: second write held while first write drains (reg0 is 0x11)
    @(negedge clk);
    busValid = 1'b1; busWrite = 1'b1; busAddr = 4'd0; busWdata = 8'h7F;
    @(negedge clk);
    busAddr = 4'd1; busWdata = 8'h7F;
    collect("R9");
    check("R9", "first group count", gotN, 32'd5);
    check("R8", "first group ev0", {25'd0, got[0]}, {25'd0, 1'b1, 6'd2});
    check("R8", "first group ev1", {25'd0, got[1]}, {25'd0, 1'b1, 6'd3});
    check("R10", "first group ev2", {25'd0, got[2]}, {25'd0, 1'b1, 6'd5});
    check("R8", "first group ev4", {25'd0, got[4]}, {25'd0, 1'b1, 6'd7});
    check("R9", "ready before second accept", {31'd0, busReady}, 32'd1);
    @(negedge clk);
    busValid = 1'b0; busWrite = 1'b0;
    collect("R9");
    check("R9", "second group count", gotN, 32'd6);
    check("R3", "second group ev0", {25'd0, got[0]}, {25'd0, 1'b0, 6'd2});
    check("R8", "second group ev5", {25'd0, got[5]}, {25'd0, 1'b0, 6'd8});
    doRead(4'd0, rd); check("R3", "reg0 after both writes", {24'd0, rd}, 32'h00);

    done = 1'b1;
    finishRun();
  end

endmodule